// File: doc/BRIEF.md
# Clock Deskew Controller

This block is the digital half of an active skew-compensation loop for one clock region. Once per reference clock period a pulse on `sample_valid` presents a binary phase comparison between the reference clock and the feedback clock taken from the region's distributed network. The controller keeps a delay-line setting in a control register. Each bit pattern of that register switches passive loads onto the line, so one code step equals one fixed delay increment. The controller moves this setting by one step only after the comparison has given the same answer for several periods in a row. It then ignores a short settle window so that the line can respond before new results count.

The filter is a small state machine with two states. `ST_TRACK` counts consecutive agreeing samples. `ST_SETTLE` ignores samples after a code change. There are two transitions. TRACK to SETTLE happens on the sample that completes a run and actually moves the code. SETTLE to TRACK happens on the last ignored sample of the window. A programmable signed offset biases the code loaded at reset, so a region can be deliberately shifted to borrow time. Flags report when the code sits at either end of its range. A lock flag reports a long stretch of periods without adjustment. An enable input freezes the code while sampling continues.

Top module: `deskew_ctrl`

## Requirements
- R1: While `rst` is high, at each clock edge the code loads 2^(CODE_W-1) plus the signed `skew_offset`, clamped to 0..2^CODE_W-1, and all counters clear. With defaults, offset 0 gives code 32 and `locked` is low.
- R2: `phase_lag`=1 means the region needs more delay. On the fourth consecutive sample with `phase_lag`=1, the code rises by exactly one, visible after that sample's clock edge.
- R3: On the fourth consecutive sample with `phase_lag`=0, the code falls by exactly one.
- R4: A sample whose phase differs from the previous one restarts the run at one. Strictly alternating samples never move the code.
- R5: After a code change, the next 2 samples are ignored. The earliest next change therefore comes on the 6th following sample.
- R6: The code saturates at 0 and at 2^CODE_W-1 without wrapping. `at_min` is high exactly when the code is 0, and `at_max` exactly when it is the maximum.
- R7: While `enable` is low at a sample, a completed run changes nothing. Samples are still taken, and the run count clears.
- R8: `locked` goes high once 16 samples in a row pass without a code change, and drops after the sample that changes the code.
- R9: Clock cycles with `sample_valid` low have no effect, whatever `phase_lag` carries.
- R10: In a closed loop where the feedback delay is linear in the code plus a fixed skew, the code settles within one step of the delay-matching value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | One-cycle pulse per reference period; phase result valid |
| phase_lag | input | 1 | Synchronized phase result: 1 = more delay needed, 0 = less |
| enable | input | 1 | Low freezes the code |
| skew_offset | input | OFS_W | Signed bias added to the mid-range reset code |
| code | output | CODE_W | Delay-line load-select code |
| at_min | output | 1 | Code is at 0 |
| at_max | output | 1 | Code is at its maximum |
| locked | output | 1 | No adjustment over the last 16 samples |

## Verification
A corrupted agreement count shows at the `code` port within a few samples: a step arrives one or more samples early or late, or alternating input moves the code. A stuck settle counter shifts the second step away from the 6th sample after the first one. A wrong lock count makes `locked` rise at the wrong sample. A saturation fault shows as a wrapped code or a wrong flag on the very next sample. The bench compares every port after every sample against a reference model. Any divergence is therefore reported at the first sample where it becomes visible.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
    typedef enum logic {
        ST_TRACK  = 1'b0,
        ST_SETTLE = 1'b1
    } flt_state_e;
endpackage

// File: rtl/deskew_run_filter.sv
// Consecutive-agreement filter with a post-step settle window.
module deskew_run_filter
    import deskew_pkg::*;
#(
    parameter int RUN_LEN    = 4,
    parameter int SETTLE_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sample,
    input  logic phase_lag,
    input  logic enable,
    input  logic moved,
    output logic req_up,
    output logic req_dn
);
    localparam int AW = $clog2(RUN_LEN + 1);
    localparam int SW = $clog2(SETTLE_LEN + 1);

    flt_state_e      state_q, state_d;
    logic [AW-1:0]   agree_q, agree_d, agree_inc;
    logic [SW-1:0]   settle_q, settle_d;
    logic            last_q, last_d;
    logic            run_done;

    // length of the run including the current sample
    assign agree_inc = (agree_q == '0 || phase_lag == last_q) ? agree_q + AW'(1) : AW'(1);
    assign run_done  = sample && (state_q == ST_TRACK) && (agree_inc == AW'(RUN_LEN));

    // next-state logic
    always_comb begin
        state_d  = state_q;
        agree_d  = agree_q;
        settle_d = settle_q;
        last_d   = last_q;
        if (sample) begin
            unique case (state_q)
                ST_TRACK: begin
                    last_d  = phase_lag;
                    agree_d = run_done ? '0 : agree_inc;
                    if (moved) begin
                        state_d  = ST_SETTLE;
                        settle_d = '0;
                    end
                end
                ST_SETTLE: begin
                    if (settle_q == SW'(SETTLE_LEN - 1)) begin
                        state_d  = ST_TRACK;
                        settle_d = '0;
                    end else begin
                        settle_d = settle_q + SW'(1);
                    end
                end
                default: state_d = ST_TRACK;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_TRACK;
            agree_q  <= '0;
            settle_q <= '0;
            last_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            agree_q  <= agree_d;
            settle_q <= settle_d;
            last_q   <= last_d;
        end
    end

    // outputs
    always_comb begin
        req_up = run_done && enable && phase_lag;
        req_dn = run_done && enable && !phase_lag;
    end

    a_r5_quiet_settle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETTLE) |-> (!req_up && !req_dn));

    a_r5_settle_entry: assert property (@(posedge clk) disable iff (rst)
        moved |=> (state_q == ST_SETTLE));

    a_r4_run_bound: assert property (@(posedge clk) disable iff (rst)
        agree_q < AW'(RUN_LEN));
endmodule

// File: rtl/deskew_code_reg.sv
// Saturating delay-line code register with lock tracking.
module deskew_code_reg #(
    parameter int CODE_W   = 6,
    parameter int OFS_W    = 4,
    parameter int LOCK_LEN = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample,
    input  logic                     inc,
    input  logic                     dec,
    input  logic signed [OFS_W-1:0]  offset,
    output logic [CODE_W-1:0]        code,
    output logic                     at_min,
    output logic                     at_max,
    output logic                     moved,
    output logic                     locked
);
    localparam int MAXC = (2 ** CODE_W) - 1;
    localparam int MID  = 2 ** (CODE_W - 1);
    localparam int LW   = $clog2(LOCK_LEN + 1);

    logic [CODE_W-1:0] code_q;
    logic [LW-1:0]     lock_q;

    function automatic logic [CODE_W-1:0] reset_code(input logic signed [OFS_W-1:0] o);
        int v;
        v = MID + int'(o);
        if (v < 0)         v = 0;
        else if (v > MAXC) v = MAXC;
        return CODE_W'(v);
    endfunction

    assign at_max = (code_q == CODE_W'(MAXC));
    assign at_min = (code_q == '0);
    assign moved  = (inc && !at_max) || (dec && !at_min);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= reset_code(offset);
            lock_q <= '0;
        end else begin
            if (inc && !at_max)      code_q <= code_q + CODE_W'(1);
            else if (dec && !at_min) code_q <= code_q - CODE_W'(1);
            if (sample) begin
                if (moved)                        lock_q <= '0;
                else if (lock_q != LW'(LOCK_LEN)) lock_q <= lock_q + LW'(1);
            end
        end
    end

    assign code   = code_q;
    assign locked = (lock_q == LW'(LOCK_LEN));

    a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
        (code_q != $past(code_q)) |->
            (code_q == $past(code_q) + CODE_W'(1) || code_q == $past(code_q) - CODE_W'(1)));

    a_r6_hold_max: assert property (@(posedge clk) disable iff (rst)
        (at_max && inc) |=> at_max);

    a_r6_hold_min: assert property (@(posedge clk) disable iff (rst)
        (at_min && dec) |=> at_min);

    a_r8_lock_drop: assert property (@(posedge clk) disable iff (rst)
        moved |=> !locked);
endmodule

// File: rtl/deskew_ctrl.sv
// Digital control loop of a per-region clock deskew scheme.
module deskew_ctrl #(
    parameter int CODE_W     = 6,
    parameter int OFS_W      = 4,
    parameter int RUN_LEN    = 4,
    parameter int SETTLE_LEN = 2,
    parameter int LOCK_LEN   = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sample_valid,
    input  logic                    phase_lag,
    input  logic                    enable,
    input  logic signed [OFS_W-1:0] skew_offset,
    output logic [CODE_W-1:0]       code,
    output logic                    at_min,
    output logic                    at_max,
    output logic                    locked
);
    logic req_up, req_dn, moved;

    deskew_run_filter #(
        .RUN_LEN    (RUN_LEN),
        .SETTLE_LEN (SETTLE_LEN)
    ) u_filter (
        .clk       (clk),
        .rst       (rst),
        .sample    (sample_valid),
        .phase_lag (phase_lag),
        .enable    (enable),
        .moved     (moved),
        .req_up    (req_up),
        .req_dn    (req_dn)
    );

    deskew_code_reg #(
        .CODE_W   (CODE_W),
        .OFS_W    (OFS_W),
        .LOCK_LEN (LOCK_LEN)
    ) u_code (
        .clk    (clk),
        .rst    (rst),
        .sample (sample_valid),
        .inc    (req_up),
        .dec    (req_dn),
        .offset (skew_offset),
        .code   (code),
        .at_min (at_min),
        .at_max (at_max),
        .moved  (moved),
        .locked (locked)
    );

    a_r7_freeze: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(code));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> $stable(code));
endmodule

// File: tb/test_deskew_ctrl.sv
module test_deskew_ctrl;
    localparam int CODE_W  = 6;
    localparam int OFS_W   = 4;
    localparam int MAXC    = 63;
    localparam int STEP_PS = 15;
    localparam int REF_PS  = 1200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_valid = 1'b0;
    logic phase_lag = 1'b0;
    logic enable = 1'b1;
    logic signed [OFS_W-1:0] skew_offset = '0;
    logic [CODE_W-1:0] code;
    logic at_min, at_max, locked;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_code, m_agree, m_settle, m_lock;
    bit m_last;

    always #2 clk = ~clk;

    deskew_ctrl i_deskew_ctrl (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .phase_lag    (phase_lag),
        .enable       (enable),
        .skew_offset  (skew_offset),
        .code         (code),
        .at_min       (at_min),
        .at_max       (at_max),
        .locked       (locked)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int clamp_code(input int v);
        if (v < 0) return 0;
        if (v > MAXC) return MAXC;
        return v;
    endfunction

    task automatic model_reset(input int off);
        m_code = clamp_code(32 + off);
        m_agree = 0; m_settle = 0; m_lock = 0; m_last = 1'b0;
    endtask

    task automatic model_sample(input bit lag, input bit en);
        bit mv;
        mv = 1'b0;
        if (m_settle > 0) begin
            m_settle--;
        end else begin
            if (m_agree == 0 || lag == m_last) m_agree++;
            else m_agree = 1;
            m_last = lag;
            if (m_agree == 4) begin
                m_agree = 0;
                if (en && lag && m_code < MAXC) begin m_code++; mv = 1'b1; end
                if (en && !lag && m_code > 0)   begin m_code--; mv = 1'b1; end
            end
        end
        if (mv) begin m_settle = 2; m_lock = 0; end
        else if (m_lock < 16) m_lock++;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " code"}, int'(code), m_code);
        chk({tag, " at_min"}, int'(at_min), int'(m_code == 0));
        chk({tag, " at_max"}, int'(at_max), int'(m_code == MAXC));
        chk({tag, " locked"}, int'(locked), int'(m_lock == 16));
    endtask

    task automatic do_reset(input int off);
        @(negedge clk);
        rst = 1'b1; sample_valid = 1'b0;
        skew_offset = OFS_W'(off);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset(off);
    endtask

    // one sample pulse, then gap idle cycles with noise on phase_lag (R9)
    task automatic send(input bit lag, input int gap);
        @(negedge clk);
        sample_valid = 1'b1; phase_lag = lag;
        @(negedge clk);
        sample_valid = 1'b0; phase_lag = ~lag;
        model_sample(lag, enable);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            phase_lag = 1'($urandom % 2);
        end
    endtask

    task automatic send_n(input bit lag, input int n);
        for (int i = 0; i < n; i++) send(lag, 0);
    endtask

    initial begin
        void'($urandom(32'd1357));
        // R1 reset state
        do_reset(0);
        @(negedge clk);
        chk("R1 reset code", int'(code), 32);
        chk("R1 reset locked", int'(locked), 0);
        check_all("R1");

        // R2: three lags hold, fourth steps up
        send_n(1'b1, 3);
        chk("R2 no step before 4", int'(code), 32);
        send(1'b1, 0);
        chk("R2 step up", int'(code), 33);

        // R5: five further lags do not step, sixth does
        send_n(1'b1, 5);
        chk("R5 settle hold", int'(code), 33);
        send(1'b1, 0);
        chk("R5 step after settle", int'(code), 34);

        // R3: down steps
        send_n(1'b0, 2);
        send_n(1'b0, 4);
        chk("R3 step down", int'(code), 33);

        // R4: disagreement restarts the run
        send_n(1'b0, 2);
        send_n(1'b1, 3); send(1'b0, 0); send_n(1'b1, 3);
        chk("R4 broken run", int'(code), 33);
        send(1'b1, 0);
        chk("R4 run of four", int'(code), 34);
        send_n(1'b1, 2);
        for (int i = 0; i < 24; i++) send(1'(i % 2), 0);
        chk("R4 alternating", int'(code), 34);
        chk("R8 locked after quiet", int'(locked), 1);
        check_all("R4/R8");

        // R9: idle cycles between samples and noise do nothing
        send(1'b0, 5); send(1'b0, 3); send(1'b0, 7);
        chk("R9 idle no effect", int'(code), 34);
        send(1'b0, 2);
        chk("R9 gapped run", int'(code), 33);
        chk("R8 lock drop", int'(locked), 0);

        // R7: frozen code with enable low
        @(negedge clk); enable = 1'b0;
        send_n(1'b0, 10);
        chk("R7 frozen", int'(code), 33);
        send_n(1'b0, 10);
        chk("R7 R8 lock while frozen", int'(locked), 1);
        @(negedge clk); enable = 1'b1;
        check_all("R7");

        // R6 top end with positive offset
        do_reset(7);
        @(negedge clk);
        chk("R1 offset +7", int'(code), 39);
        for (int i = 0; i < 200; i++) send(1'b1, 0);
        chk("R6 saturate max", int'(code), MAXC);
        chk("R6 at_max", int'(at_max), 1);
        check_all("R6 max");

        // R6 bottom end with negative offset
        do_reset(-8);
        @(negedge clk);
        chk("R1 offset -8", int'(code), 24);
        for (int i = 0; i < 180; i++) send(1'b0, 0);
        chk("R6 saturate min", int'(code), 0);
        chk("R6 at_min", int'(at_min), 1);
        check_all("R6 min");

        // random runs, gaps and enable against the model
        do_reset(3);
        for (int r = 0; r < 120; r++) begin
            bit lag;
            int len;
            lag = 1'($urandom % 2);
            len = 1 + int'($urandom % 7);
            @(negedge clk); enable = ($urandom % 8) != 0;
            for (int k = 0; k < len; k++) send(lag, int'($urandom % 3));
            check_all("R2/R3/R4/R7 random");
        end
        @(negedge clk); enable = 1'b1;

        // R10 closed loop with linear delay plant
        for (int t = 0; t < 4; t++) begin
            int skew_ps, err;
            skew_ps = 400 + int'($urandom % 700);
            do_reset(int'($urandom % 16) - 8);
            for (int i = 0; i < 400; i++) begin
                send((int'(code) * STEP_PS + skew_ps) < REF_PS, int'($urandom % 2));
            end
            check_all("R10 loop");
            err = int'(code) * STEP_PS + skew_ps - REF_PS;
            if (err < 0) err = -err;
            chk("R10 within one step", int'(err <= STEP_PS), 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule